// File: doc/BRIEF.md
# Integer to Single-Precision Float Converter with Selectable Rounding

This block turns a signed 32-bit two's-complement integer into the bit pattern of an IEEE-754 single-precision number. It first forms the magnitude of the input and finds its most significant set bit. It then shifts that bit to the position just above the 23-bit fraction and builds the biased exponent from that bit's position. Any magnitude bits that do not fit in the 24-bit significand are removed by rounding. A 2-bit input selects one of four rounding directions.

A caller presents a word together with a valid strobe and a rounding selection. One clock later the block returns the packed float, a valid flag and a flag that reports whether the result lost precision. The output register only loads when the valid strobe is high, so the result stays put between conversions. The input range cannot produce a subnormal result.

Top module: `i2f_round`

## Requirements
- R1: `res_valid` is high in the cycle after a cycle in which `src_valid` was high, and low in the cycle after a cycle in which `src_valid` was low. After reset, `res_valid` is 0 and `res_bits` is 0.
- R2: A zero input gives `res_bits` = 0x00000000 with `res_inexact` = 0, whatever the rounding mode.
- R3: `res_bits[31]` equals the input sign bit. The input 0x80000000 (-2^31) gives 0xCF000000 with `res_inexact` = 0.
- R4: When the magnitude is below 2^24, the result is exact. The exponent field `res_bits[30:23]` equals the leading-one position plus 127. The fraction `res_bits[22:0]` holds the bits below the leading one, left-aligned, with the leading one itself omitted. `res_inexact` is 0.
- R5: When `rnd_mode` = 2'b11 (toward zero), the discarded magnitude bits are dropped. For example, 2147483583 gives 0x4EFFFFFF and 67108871 gives 0x4C800000.
- R6: When `rnd_mode` = 2'b00 (nearest, ties to even), the magnitude rounds to the closer candidate. On an exact tie it rounds to the candidate whose fraction LSB is 0. For example, 67108871 gives 0x4C800001, 16777217 gives 0x4B800000, and 16777219 gives 0x4B800002.
- R7: When `rnd_mode` = 2'b01 (toward minus infinity), the magnitude is increased only for a negative inexact input. When `rnd_mode` = 2'b10 (toward plus infinity), the magnitude is increased only for a positive inexact input.
- R8: When rounding up carries out of the 24-bit significand, the fraction becomes 0 and the exponent goes up by one. For example, 2147483584 in mode 2'b00 gives 0x4F000000.
- R9: `res_inexact` is 1 exactly when at least one discarded magnitude bit is nonzero.
- R10: While `src_valid` is low, `res_bits` and `res_inexact` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Input word is valid this cycle |
| src_int | input | 32 | Signed integer to convert |
| rnd_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero |
| res_valid | output | 1 | Result is valid |
| res_bits | output | 32 | Single-precision bit pattern |
| res_inexact | output | 1 | Some discarded bit was nonzero |

## Verification
The bench aims at several specific corner cases:
- Exact ties in nearest-even mode. A design that always rounds half up would return 0x4B800001 for 16777217.
- Significand overflow on round-up. A design that missed it would wrap the fraction to zero without raising the exponent, giving half the true value.
- The most negative input. A naive negation path could report it as inexact or give it the wrong exponent.
- Directed rounding on both signs. This exposes a design that applies the direction to the magnitude instead of to the signed value; such a design would swap the results for negative inputs.

// File: rtl/i2f_round.sv
module i2f_round (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_valid,
  input  logic [31:0] src_int,
  input  logic [1:0]  rnd_mode,
  output logic        res_valid,
  output logic [31:0] res_bits,
  output logic        res_inexact
);

  logic        sgn;
  logic [31:0] mag;
  logic [4:0]  top;
  logic [31:0] norm;
  logic        guard, sticky, lost, bump, carry, nz;
  logic [22:0] frac;
  logic [7:0]  expo;
  logic [31:0] packed_f;

  assign sgn = src_int[31];
  assign mag = sgn ? (~src_int + 32'd1) : src_int;

  always_comb begin
    top = 5'd0;
    for (int i = 0; i < 32; i++)
      if (mag[i]) top = i[4:0];
  end

  assign norm   = mag << (5'd31 - top);
  assign nz     = norm[31];
  assign guard  = norm[7];
  assign sticky = |norm[6:0];
  assign lost   = guard | sticky;

  always_comb begin
    case (rnd_mode)
      2'b00:   bump = guard & (sticky | norm[8]);
      2'b01:   bump = sgn & lost;
      2'b10:   bump = ~sgn & lost;
      default: bump = 1'b0;
    endcase
  end

  assign carry    = bump & (&norm[30:8]);
  assign frac     = norm[30:8] + {22'd0, bump};
  assign expo     = {3'd0, top} + 8'd127 + {7'd0, carry};
  assign packed_f = nz ? {sgn, expo, frac} : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_bits    <= 32'd0;
      res_inexact <= 1'b0;
    end else begin
      res_valid <= src_valid;
      if (src_valid) begin
        res_bits    <= packed_f;
        res_inexact <= lost;
      end
    end
  end

endmodule

// File: rtl/i2f_round_chk.sv
module i2f_round_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src_valid,
  input logic [31:0] src_int,
  input logic        res_valid,
  input logic [31:0] res_bits,
  input logic        res_inexact
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> res_valid);

  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> !res_valid);

  a_r2_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_int == 32'd0) |=> (res_bits == 32'd0 && !res_inexact));

  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_int != 32'd0) |=> (res_bits[31] == $past(src_int[31])));

  a_r4_small_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_int[31:24] == 8'd0) |=> !res_inexact);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> ($stable(res_bits) && $stable(res_inexact)));

endmodule

bind i2f_round i2f_round_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_int(src_int),
  .res_valid(res_valid), .res_bits(res_bits), .res_inexact(res_inexact)
);

// File: tb/sim_i2f_round.sv
module sim_i2f_round;
  localparam int PERIOD = 10;
  localparam int NV = 22;

  // {mode, input, expected bits, expected inexact}
  localparam logic [66:0] VEC [NV] = '{
    {2'b00, 32'h00000000, 32'h00000000, 1'b0},  // R2
    {2'b10, 32'h00000000, 32'h00000000, 1'b0},  // R2
    {2'b00, 32'h00000001, 32'h3F800000, 1'b0},  // R4
    {2'b00, 32'hFFFFFFFF, 32'hBF800000, 1'b0},  // R3 R4
    {2'b00, 32'h00000003, 32'h40400000, 1'b0},  // R4
    {2'b01, 32'h80000000, 32'hCF000000, 1'b0},  // R3
    {2'b11, 32'h7FFFFFBF, 32'h4EFFFFFF, 1'b1},  // R5
    {2'b11, 32'h04000007, 32'h4C800000, 1'b1},  // R5
    {2'b00, 32'h04000007, 32'h4C800001, 1'b1},  // R6
    {2'b00, 32'h7FFFFFBF, 32'h4EFFFFFF, 1'b1},  // R6
    {2'b00, 32'h01000001, 32'h4B800000, 1'b1},  // R6 tie even down
    {2'b00, 32'h01000003, 32'h4B800002, 1'b1},  // R6 tie even up
    {2'b00, 32'h01000002, 32'h4B800001, 1'b0},  // R9 exact
    {2'b10, 32'h04000007, 32'h4C800001, 1'b1},  // R7
    {2'b01, 32'h04000007, 32'h4C800000, 1'b1},  // R7
    {2'b01, 32'hFBFFFFF9, 32'hCC800001, 1'b1},  // R7
    {2'b10, 32'hFBFFFFF9, 32'hCC800000, 1'b1},  // R7
    {2'b00, 32'h7FFFFFC0, 32'h4F000000, 1'b1},  // R8
    {2'b11, 32'h7FFFFFC0, 32'h4EFFFFFF, 1'b1},  // R5
    {2'b10, 32'h7FFFFFFF, 32'h4F000000, 1'b1},  // R8
    {2'b01, 32'h7FFFFFFF, 32'h4EFFFFFF, 1'b1},  // R7
    {2'b01, 32'h80000001, 32'hCF000000, 1'b1}   // R8 negative
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_valid = 1'b0;
  logic [31:0] src_int = 32'd0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        res_valid;
  logic [31:0] res_bits;
  logic        res_inexact;
  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  i2f_round u0 (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_int(src_int),
    .rnd_mode(rnd_mode), .res_valid(res_valid), .res_bits(res_bits),
    .res_inexact(res_inexact)
  );

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [1:0] m, input logic [31:0] d);
    @(negedge clk);
    rnd_mode  = m;
    src_int   = d;
    src_valid = 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset", {1'b0, res_valid, res_bits}, {1'b0, 1'b0, 32'd0});
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      convert(VEC[k][66:65], VEC[k][64:33]);
      check($sformatf("R5-R9 vector %0d", k),
            {res_valid, res_inexact, res_bits},
            {1'b1, VEC[k][0], VEC[k][32:1]});
    end

    // R1: valid drops one cycle after strobe falls
    @(negedge clk);
    check("R1 valid low", {33'd0, res_valid}, 34'd0);

    // R10: data changes without strobe leave result unchanged
    convert(2'b00, 32'h04000007);
    @(negedge clk);
    src_int  = 32'h7FFFFFFF;
    rnd_mode = 2'b10;
    @(negedge clk);
    @(negedge clk);
    check("R10 hold", {1'b0, res_inexact, res_bits}, {1'b0, 1'b1, 32'h4C800001});

    // R1: back-to-back strobes
    @(negedge clk);
    rnd_mode = 2'b00; src_int = 32'h00000001; src_valid = 1'b1;
    @(negedge clk);
    check("R1 first", {res_valid, 1'b0, res_bits}, {1'b1, 1'b0, 32'h3F800000});
    src_int = 32'h00000003;
    @(negedge clk);
    check("R1 second", {res_valid, 1'b0, res_bits}, {1'b1, 1'b0, 32'h40400000});
    src_valid = 1'b0;

    // reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", {1'b0, res_valid, res_bits}, 34'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule